// File: doc/BRIEF.md
# Autonomous Watchdog Timer with Lockable Enable

This block guards a processor against runaway code. It counts ticks from a slow, free-running timebase. If software does not restart the count before it reaches the selected timeout, the block raises a one-cycle reset request for the system reset logic. Software reaches the block through a single 8-bit control register. That register holds three things: a reset-enable bit that can be set but never cleared, a write-only restart strobe, and a rate select that picks the short or the long timeout.

A power-mode input tells the block whether the device is in RUN or STOP. In STOP the count is held where it is. On the return to RUN, counting resumes from the held value. The timebase is modelled by a single-cycle tick input. The two timeouts are parameters given in ticks, nominally 10 ms and 20 ms of a 1 kHz tick.

Top module: `awd_timer`

## Requirements
- R1: After rst_n is released, the control register reads 0x00 and rst_req is 0.
- R2: While the enable bit (bit 2) is 0, no number of ticks produces a reset request.
- R3: Once bit 2 has been written as 1, later writes of 0 to bit 2 leave it reading 1; only rst_n clears it.
- R4: Bits 7 to 3 and the restart bit (bit 1) always read 0, whatever was written. Bit 0 reads back the last value written.
- R5: With bit 0 = 0 (slow rate), rst_req rises one clock after the SLOW_TICKS-th counted tick following enable or restart, and not earlier.
- R6: With bit 0 = 1 (fast rate), rst_req rises one clock after the FAST_TICKS-th counted tick following enable or restart, and not earlier.
- R7: A register write with bit 1 = 1 starts a fresh full timeout period. A write with bit 1 = 0 leaves the running count unchanged.
- R8: Ticks are counted only while run_mode is 1 (RUN). While run_mode is 0 (STOP) the count is held, and it resumes from the held value when run_mode returns to 1.
- R9: rst_req is high for exactly one clock. The count then restarts, so the next request follows after another full period.
- R10: Writes to any address other than REG_ADDR (0x0A) have no effect, and reads of other addresses return 0x00.
- R11: Asserting rst_n returns the block to its reset state, with the watchdog disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tick | input | 1 | Single-cycle timebase tick from the watchdog oscillator |
| run_mode | input | 1 | 1 = RUN, 0 = STOP |
| wr | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count or a wrong terminal value shows at rst_req as a request one or more ticks early or late. It is therefore visible within one timeout period, at most SLOW_TICKS ticks. A lost enable, or one that was cleared, shows at once on a register read and, after one period, as a missing request. A restart or STOP hold that fails to act moves the next request earlier by the number of ticks already counted. The bench sweeps the restart point across every tick position at both rates to expose this.

// File: rtl/awd_timer.sv
module awd_timer #(
  parameter int FAST_TICKS = 10,
  parameter int SLOW_TICKS = 20,
  parameter logic [7:0] REG_ADDR = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run_mode,
  input  logic       wr,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rst_req
);
  localparam int MAXT = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int CW   = $clog2(MAXT) + 1;

  logic          en_q, rate_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          hit, counting;

  assign hit      = wr && (addr == REG_ADDR);
  assign last     = rate_q ? CW'(FAST_TICKS - 1) : CW'(SLOW_TICKS - 1);
  assign counting = en_q && run_mode && tick;
  assign rdata    = (addr == REG_ADDR) ? {5'b0, en_q, 1'b0, rate_q} : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rate_q  <= 1'b0;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (hit) begin
        rate_q <= wdata[0];
        if (wdata[2]) en_q <= 1'b1;
      end
      if (hit && wdata[1]) begin
        cnt <= '0;
      end else if (counting) begin
        if (cnt >= last) begin
          cnt     <= '0;
          rst_req <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module awd_timer_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          run_mode,
  input logic          wr,
  input logic          en_q,
  input logic [CW-1:0] cnt,
  input logic [7:0]    rdata,
  input logic          rst_req
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(en_q));
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_mode && !wr) |=> $stable(cnt));
  a_r8_fire_on_run_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(run_mode && tick));
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[7:3] == 5'b0) && !rdata[1]);
endmodule

bind awd_timer awd_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run_mode(run_mode), .wr(wr),
  .en_q(en_q), .cnt(cnt), .rdata(rdata), .rst_req(rst_req)
);

// File: tb/awd_timer_tb.sv
module awd_timer_tb;
  localparam int FT = 10;
  localparam int ST = 20;
  localparam logic [7:0] RA = 8'h0A;

  logic clk = 0, rst_n = 0, tick = 0, run_mode = 1, wr = 0;
  logic [7:0] addr = RA, wdata = 0, rdata;
  logic rst_req;
  int checks = 0, errors = 0;
  bit done = 0;

  awd_timer #(.FAST_TICKS(FT), .SLOW_TICKS(ST), .REG_ADDR(RA)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_mode(run_mode), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; wr = 0; run_mode = 1; addr = RA;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = RA;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = RA;
  endtask

  task automatic ticks(input int n, output int first, output int nfire);
    first = 0; nfire = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      if (rst_req) begin
        nfire++;
        if (first == 0) first = i;
      end
      @(negedge clk);
      if (rst_req) chk(0, "R9 pulse width", 1, 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f, n, term;
    logic [7:0] d;
    do_reset();
    rreg(RA, d);
    chk(d == 8'h00, "R1 reset read", d, 0);
    chk(rst_req == 0, "R1 reset rst_req", rst_req, 0);

    wreg(RA, 8'h00); ticks(50, f, n);
    chk(n == 0, "R2 disabled slow", n, 0);
    wreg(RA, 8'h01); ticks(30, f, n);
    chk(n == 0, "R2 disabled fast", n, 0);

    for (int r = 0; r < 2; r++) begin
      term = r ? FT : ST;
      do_reset(); wreg(RA, 8'h04 | 8'(r));
      ticks(2 * term, f, n);
      if (r) chk(f == term, "R6 fast timeout", f, term);
      else   chk(f == term, "R5 slow timeout", f, term);
      chk(n == 2, "R9 second period", n, 2);
    end

    for (int r = 0; r < 2; r++) begin
      term = r ? FT : ST;
      for (int k = 1; k < term; k++) begin
        do_reset(); wreg(RA, 8'h04 | 8'(r));
        ticks(k, f, n);
        wreg(RA, 8'h06 | 8'(r));
        ticks(term, f, n);
        chk(f == term && n == 1, "R7 restart fresh period", f, term);
        do_reset(); wreg(RA, 8'h04 | 8'(r));
        ticks(k, f, n);
        wreg(RA, 8'h04 | 8'(r));
        ticks(term, f, n);
        chk(f == term - k, "R7 no restart on bit1=0", f, term - k);
      end
    end

    do_reset(); wreg(RA, 8'h04);
    ticks(5, f, n);
    @(negedge clk); run_mode = 0;
    ticks(40, f, n);
    chk(n == 0, "R8 stop no fire", n, 0);
    @(negedge clk); run_mode = 1;
    ticks(ST, f, n);
    chk(f == ST - 5, "R8 resume from held", f, ST - 5);

    do_reset(); wreg(RA, 8'h04); wreg(RA, 8'h00);
    rreg(RA, d);
    chk(d == 8'h04, "R3 enable sticky", d, 4);
    ticks(ST, f, n);
    chk(f == ST, "R3 still active", f, ST);
    wreg(RA, 8'hFF); rreg(RA, d);
    chk(d == 8'h05, "R4 reserved and restart read 0", d, 5);
    wreg(RA, 8'hFA); rreg(RA, d);
    chk(d == 8'h04, "R4 rate reads back", d, 4);

    do_reset(); wreg(8'h0B, 8'hFF); wreg(8'h00, 8'h07);
    rreg(RA, d);
    chk(d == 8'h00, "R10 other address write", d, 0);
    rreg(8'h0B, d);
    chk(d == 8'h00, "R10 other address read", d, 0);
    ticks(30, f, n);
    chk(n == 0, "R10 stays disabled", n, 0);

    wreg(RA, 8'h05); ticks(3, f, n);
    do_reset(); rreg(RA, d);
    chk(d == 8'h00, "R11 reset clears", d, 0);
    ticks(30, f, n);
    chk(n == 0, "R11 disabled after reset", n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule